// File: doc/BRIEF.md
# CAN Transmit Buffer Priority Arbiter

This block decides which of several transmit message buffers goes next to the CAN protocol engine. The host arms a buffer once its frame content is ready. Each armed buffer then competes using its identifier, its standard/extended flag and a small local priority field. A mode input chooses the ordering rule: lowest identifier, lowest buffer index, or the local priority placed ahead of the identifier. The winner is shown as an index with a valid flag. The engine takes it with a start pulse and later reports either done or lost. A lost report covers both lost arbitration and a failed frame.

The host can cancel a pending buffer at any time. An idle buffer is withdrawn at once. A buffer already on the bus is only withdrawn if its frame then fails. Each buffer keeps sticky "sent" and "cancelled" status bits. Both bits are cleared when the buffer is armed again.

Top module: `can_tx_arbiter`

## Requirements
- R1: After reset, sel_valid_o is 0 and all bits of sent_o and cancelled_o are 0.
- R2: With mode_i = 0 (or 3), the armed buffer with the smallest arbitration key wins. For a standard buffer (ide = 0) the key is {id[10:0], 0, 18'b0}. For an extended buffer (ide = 1) it is {id[28:18], 1, id[17:0]}.
- R3: A standard buffer beats an extended buffer whose id[28:18] equals its 11-bit identifier.
- R4: With mode_i = 1, the armed buffer with the lowest index wins, whatever its identifier.
- R5: With mode_i = 2, the comparison uses {prio, key}, and a lower prio value wins. A change of mode_i shows in the offer one cycle later.
- R6: When keys are equal, the lower buffer index wins.
- R7: sel_valid_o is 1 only while no frame is in flight and at least one buffer is armed and pending. An arm pulse shows in the offer one cycle later. The offer drops in the cycle after tx_start_i.
- R8: tx_done_i sets the in-flight buffer's sent_o bit and removes the buffer from arbitration. The next winner is offered in the following cycle.
- R9: tx_lost_i ends the flight without sending. If the buffer was not cancelled, it competes again in the next pass, together with any buffers armed in the meantime.
- R10: A cancel pulse on a pending buffer that is not in flight removes it at once and sets its cancelled_o bit. The bit stays set, and the buffer is not offered again.
- R11: A cancel on the in-flight buffer does not stop the frame. If tx_done_i follows, sent_o is set and cancelled_o stays 0.
- R12: A cancel on the in-flight buffer followed by tx_lost_i sets cancelled_o and removes the buffer.
- R13: An arm pulse clears the buffer's sent_o and cancelled_o bits and makes it pending again. It is ignored while that buffer is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Ordering rule: 0 lowest ID, 1 lowest index, 2 local priority, 3 as 0 |
| arm_i | input | NUM_BUF | Per-buffer arm pulse |
| cancel_i | input | NUM_BUF | Per-buffer cancel pulse |
| ide_i | input | NUM_BUF | Per-buffer extended-identifier flag |
| id_i | input | NUM_BUF*29 | Per-buffer identifier, buffer i at bits [29*i +: 29] |
| prio_i | input | NUM_BUF*PRIO_W | Per-buffer local priority |
| tx_start_i | input | 1 | Engine takes the offered buffer |
| tx_done_i | input | 1 | In-flight frame sent |
| tx_lost_i | input | 1 | In-flight frame lost arbitration or failed |
| sel_idx_o | output | $clog2(NUM_BUF) | Offered buffer index |
| sel_valid_o | output | 1 | Offer valid |
| sent_o | output | NUM_BUF | Sticky sent status |
| cancelled_o | output | NUM_BUF | Sticky cancelled status |

## Verification
The assertions rely on the engine being well behaved. It pulses tx_start_i only while sel_valid_o is 1. It pulses tx_done_i or tx_lost_i only while a frame is in flight, and never both in the same cycle. Identifiers and priorities are assumed stable while their buffer is pending. The bench drives every handshake through tasks that keep these rules. It changes a buffer's identifier or priority only before arming that buffer. Each pulse lasts exactly one cycle.

// File: rtl/can_txarb_pkg.sv
package can_txarb_pkg;
  localparam int ID_W  = 29;
  localparam int KEY_W = 30; // base11 + ide + ext18

  typedef enum logic [1:0] {
    MODE_LOW_ID  = 2'd0,
    MODE_LOW_IDX = 2'd1,
    MODE_LOCAL   = 2'd2,
    MODE_ALT_ID  = 2'd3
  } txarb_mode_e;
endpackage

// File: rtl/can_txarb_key.sv
module can_txarb_key
  import can_txarb_pkg::*;
#(
  parameter int PRIO_W = 3,
  localparam int KW    = PRIO_W + KEY_W
) (
  input  logic [1:0]      mode_i,
  input  logic            ide_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic [KW-1:0]   key_o
);
  logic [KEY_W-1:0] bus_key;

  // bus order: base bits, then IDE (std=0 wins), then extension
  always_comb begin
    if (ide_i) bus_key = {id_i[28:18], 1'b1, id_i[17:0]};
    else       bus_key = {id_i[10:0], 1'b0, 18'b0};
  end

  always_comb begin
    case (txarb_mode_e'(mode_i))
      MODE_LOW_IDX: key_o = '0;
      MODE_LOCAL:   key_o = {prio_i, bus_key};
      default:      key_o = {{PRIO_W{1'b0}}, bus_key};
    endcase
  end
endmodule

// File: rtl/can_txarb_pick.sv
module can_txarb_pick #(
  parameter int NUM_BUF = 8,
  parameter int KW      = 33,
  localparam int IW     = $clog2(NUM_BUF),
  localparam int P      = 1 << IW
) (
  input  logic [NUM_BUF-1:0] vld_i,
  input  logic [KW-1:0]      key_i [NUM_BUF],
  output logic               vld_o,
  output logic [IW-1:0]      idx_o
);
  logic          nv [2*P-1];
  logic [KW-1:0] nk [2*P-1];
  logic [IW-1:0] ni [2*P-1];

  for (genvar j = 0; j < P; j++) begin : g_leaf
    if (j < NUM_BUF) begin : g_real
      assign nv[P-1+j] = vld_i[j];
      assign nk[P-1+j] = key_i[j];
    end else begin : g_pad
      assign nv[P-1+j] = 1'b0;
      assign nk[P-1+j] = '0;
    end
    assign ni[P-1+j] = IW'(j);
  end

  // left subtree holds lower indices: ties go left
  for (genvar j = 0; j < P-1; j++) begin : g_node
    logic take_l;
    assign take_l = nv[2*j+1] && (!nv[2*j+2] || (nk[2*j+1] <= nk[2*j+2]));
    assign nv[j]  = nv[2*j+1] | nv[2*j+2];
    assign nk[j]  = take_l ? nk[2*j+1] : nk[2*j+2];
    assign ni[j]  = take_l ? ni[2*j+1] : ni[2*j+2];
  end

  assign vld_o = nv[0];
  assign idx_o = ni[0];
endmodule

// File: rtl/can_txarb_bufs.sv
module can_txarb_bufs #(
  parameter int NUM_BUF = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BUF-1:0] arm_i,
  input  logic [NUM_BUF-1:0] cancel_i,
  input  logic [NUM_BUF-1:0] fly_i,
  input  logic [NUM_BUF-1:0] done_i,
  input  logic [NUM_BUF-1:0] lost_i,
  output logic [NUM_BUF-1:0] pend_d_o,
  output logic [NUM_BUF-1:0] pend_q_o,
  output logic [NUM_BUF-1:0] sent_o,
  output logic [NUM_BUF-1:0] canc_o
);
  logic [NUM_BUF-1:0] pend_q, sent_q, canc_q, creq_q;
  logic [NUM_BUF-1:0] pend_d, sent_d, canc_d, creq_d;

  always_comb begin
    pend_d = pend_q;
    sent_d = sent_q;
    canc_d = canc_q;
    creq_d = creq_q;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (done_i[i]) begin
        pend_d[i] = 1'b0;
        sent_d[i] = 1'b1;
        creq_d[i] = 1'b0;
      end else if (lost_i[i]) begin
        if (creq_q[i] || cancel_i[i]) begin
          pend_d[i] = 1'b0;
          canc_d[i] = 1'b1;
        end
        creq_d[i] = 1'b0;
      end else if (arm_i[i] && !fly_i[i]) begin
        pend_d[i] = 1'b1;
        sent_d[i] = 1'b0;
        canc_d[i] = 1'b0;
        creq_d[i] = 1'b0;
      end else if (cancel_i[i] && pend_q[i]) begin
        if (fly_i[i]) begin
          creq_d[i] = 1'b1; // deferred until outcome known
        end else begin
          pend_d[i] = 1'b0;
          canc_d[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      sent_q <= '0;
      canc_q <= '0;
      creq_q <= '0;
    end else begin
      pend_q <= pend_d;
      sent_q <= sent_d;
      canc_q <= canc_d;
      creq_q <= creq_d;
    end
  end

  assign pend_d_o = pend_d;
  assign pend_q_o = pend_q;
  assign sent_o   = sent_q;
  assign canc_o   = canc_q;

  AST_CANC_NOT_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (canc_q & pend_q) == '0); // R10
  AST_STATUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (canc_q & sent_q) == '0); // R11
  AST_CANC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((canc_q & ~arm_i) != '0) |=> ((canc_q & $past(canc_q & ~arm_i)) == $past(canc_q & ~arm_i))); // R10
endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter
  import can_txarb_pkg::*;
#(
  parameter int NUM_BUF = 8,
  parameter int PRIO_W  = 3,
  localparam int IW     = $clog2(NUM_BUF),
  localparam int KW     = PRIO_W + KEY_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [1:0]                mode_i,
  input  logic [NUM_BUF-1:0]        arm_i,
  input  logic [NUM_BUF-1:0]        cancel_i,
  input  logic [NUM_BUF-1:0]        ide_i,
  input  logic [NUM_BUF*ID_W-1:0]   id_i,
  input  logic [NUM_BUF*PRIO_W-1:0] prio_i,
  input  logic                      tx_start_i,
  input  logic                      tx_done_i,
  input  logic                      tx_lost_i,
  output logic [IW-1:0]             sel_idx_o,
  output logic                      sel_valid_o,
  output logic [NUM_BUF-1:0]        sent_o,
  output logic [NUM_BUF-1:0]        cancelled_o
);
  logic [KW-1:0]      key_w [NUM_BUF];
  logic [NUM_BUF-1:0] pend_d, pend_q;
  logic [NUM_BUF-1:0] fly_vec, done_vec, lost_vec;
  logic               busy_q, busy_d, start_ok;
  logic [IW-1:0]      busy_idx_q;
  logic               win_vld;
  logic [IW-1:0]      win_idx;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_key
    can_txarb_key #(.PRIO_W(PRIO_W)) u_key (
      .mode_i (mode_i),
      .ide_i  (ide_i[i]),
      .id_i   (id_i[i*ID_W +: ID_W]),
      .prio_i (prio_i[i*PRIO_W +: PRIO_W]),
      .key_o  (key_w[i])
    );
  end

  assign start_ok = tx_start_i & sel_valid_o;

  always_comb begin
    fly_vec  = '0;
    done_vec = '0;
    lost_vec = '0;
    if (busy_q) begin
      fly_vec  = NUM_BUF'(1) << busy_idx_q;
      if (tx_done_i)      done_vec = fly_vec;
      else if (tx_lost_i) lost_vec = fly_vec;
    end else if (start_ok) begin
      fly_vec = NUM_BUF'(1) << sel_idx_o;
    end
  end

  assign busy_d = start_ok | (busy_q & ~(tx_done_i | tx_lost_i));

  can_txarb_bufs #(.NUM_BUF(NUM_BUF)) u_bufs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_i),
    .cancel_i (cancel_i),
    .fly_i    (fly_vec),
    .done_i   (done_vec),
    .lost_i   (lost_vec),
    .pend_d_o (pend_d),
    .pend_q_o (pend_q),
    .sent_o   (sent_o),
    .canc_o   (cancelled_o)
  );

  // compete on next-state pending so a cancel is never offered stale
  can_txarb_pick #(.NUM_BUF(NUM_BUF), .KW(KW)) u_pick (
    .vld_i (pend_d),
    .key_i (key_w),
    .vld_o (win_vld),
    .idx_o (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      busy_idx_q  <= '0;
      sel_valid_o <= 1'b0;
      sel_idx_o   <= '0;
    end else begin
      busy_q      <= busy_d;
      sel_valid_o <= win_vld & ~busy_d;
      sel_idx_o   <= win_idx;
      if (start_ok) busy_idx_q <= sel_idx_o;
    end
  end

  AST_OFFER_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> pend_q[sel_idx_o]); // R7
  AST_NO_OFFER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !sel_valid_o); // R7
  AST_START_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok |=> !sel_valid_o); // R7
  AST_DONE_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tx_done_i) |=> sent_o[$past(busy_idx_q)]); // R8
  AST_WIN_CAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld |-> pend_d[win_idx]); // R6
  AST_WIN_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld == (pend_d != '0)); // R7
endmodule

// File: tb/can_tx_arbiter_bench.sv
module can_tx_arbiter_bench;
  localparam int NB = 8;
  localparam int PW = 3;
  localparam int IW = $clog2(NB);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode = 2'd0;
  logic [NB-1:0]   arm = '0, cancel = '0, ide = '0;
  logic [NB*29-1:0] id = '0;
  logic [NB*PW-1:0] prio = '0;
  logic            start = 1'b0, done = 1'b0, lost = 1'b0;
  logic [IW-1:0]   sel_idx;
  logic            sel_valid;
  logic [NB-1:0]   sent, canc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  can_tx_arbiter #(.NUM_BUF(NB), .PRIO_W(PW)) u_can_tx_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .arm_i(arm), .cancel_i(cancel),
    .ide_i(ide), .id_i(id), .prio_i(prio), .tx_start_i(start), .tx_done_i(done),
    .tx_lost_i(lost), .sel_idx_o(sel_idx), .sel_valid_o(sel_valid),
    .sent_o(sent), .cancelled_o(canc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_buf(input int i, input logic x, input logic [28:0] v, input logic [PW-1:0] p);
    ide[i] = x;
    id[i*29 +: 29] = v;
    prio[i*PW +: PW] = p;
  endtask

  task automatic do_arm(input logic [NB-1:0] m);
    arm = m; tick(); arm = '0;
  endtask

  task automatic do_cancel(input logic [NB-1:0] m);
    cancel = m; tick(); cancel = '0;
  endtask

  task automatic do_start();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic do_done();
    done = 1'b1; tick(); done = 1'b0;
  endtask

  task automatic do_lost();
    lost = 1'b1; tick(); lost = 1'b0;
  endtask

  task automatic serve(input string req, input int exp_idx);
    chk({req, " valid"}, 32'(sel_valid), 1);
    chk({req, " idx"}, 32'(sel_idx), 32'(exp_idx));
    do_start();
    do_done();
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(sel_valid), 0);
    chk("R1 sent", 32'(sent), 0);
    chk("R1 canc", 32'(canc), 0);
  endtask

  task automatic t_low_id();
    mode = 2'd0;
    set_buf(0, 1'b0, 29'h123, 0);
    set_buf(1, 1'b0, 29'h050, 0);
    set_buf(2, 1'b1, 29'h1FFFFFFF, 0);
    do_arm(8'b0000_0111);
    chk("R7 offer after arm", 32'(sel_valid), 1);
    chk("R2 lowest id", 32'(sel_idx), 1);
    do_start();
    chk("R7 drop on start", 32'(sel_valid), 0);
    do_done();
    chk("R8 sent bit", 32'(sent[1]), 1);
    serve("R8 next pass", 0);
    serve("R2 extended last", 2);
    chk("R7 none left", 32'(sel_valid), 0);
    chk("R8 all sent", 32'(sent & 8'h07), 32'h7);
  endtask

  task automatic t_std_ext();
    mode = 2'd0;
    set_buf(3, 1'b1, {11'h2AA, 18'h0}, 0);
    set_buf(5, 1'b0, 29'h2AA, 0);
    do_arm(8'b0010_1000);
    serve("R3 std over ext", 5);
    serve("R3 ext after", 3);
  endtask

  task automatic t_low_idx();
    mode = 2'd1;
    set_buf(6, 1'b0, 29'h001, 0);
    set_buf(2, 1'b0, 29'h7FF, 0);
    do_arm(8'b0100_0100);
    serve("R4 lowest index", 2);
    serve("R4 second", 6);
  endtask

  task automatic t_local();
    mode = 2'd2;
    set_buf(0, 1'b0, 29'h001, 5);
    set_buf(4, 1'b0, 29'h700, 1);
    do_arm(8'b0001_0001);
    chk("R5 prio wins", 32'(sel_idx), 4);
    mode = 2'd0;
    tick();
    chk("R5 mode switch to id", 32'(sel_idx), 0);
    mode = 2'd2;
    tick();
    serve("R5 local first", 4);
    serve("R5 local second", 0);
  endtask

  task automatic t_tie();
    mode = 2'd2;
    set_buf(1, 1'b0, 29'h155, 3);
    set_buf(6, 1'b0, 29'h155, 3);
    do_arm(8'b0100_0010);
    serve("R6 tie low index", 1);
    serve("R6 tie second", 6);
  endtask

  task automatic t_lost();
    mode = 2'd0;
    set_buf(2, 1'b0, 29'h010, 0);
    set_buf(0, 1'b0, 29'h005, 0);
    do_arm(8'b0000_0100);
    do_start();
    do_arm(8'b0000_0001);
    chk("R7 no offer in flight", 32'(sel_valid), 0);
    do_lost();
    chk("R9 not sent", 32'(sent[2]), 0);
    serve("R9 new pass", 0);
    serve("R9 retried", 2);
  endtask

  task automatic t_cancel_idle();
    mode = 2'd1;
    do_arm(8'b0010_1000);
    chk("R10 pre idx", 32'(sel_idx), 3);
    do_cancel(8'b0000_1000);
    chk("R10 canc set", 32'(canc[3]), 1);
    chk("R10 moved on", 32'(sel_idx), 5);
    serve("R10 other", 5);
    chk("R10 not re-offered", 32'(sel_valid), 0);
    chk("R10 sticky", 32'(canc[3]), 1);
  endtask

  task automatic t_cancel_fly();
    mode = 2'd1;
    do_arm(8'b0001_0000);
    do_start();
    do_cancel(8'b0001_0000);
    chk("R11 deferred", 32'(canc[4]), 0);
    do_done();
    chk("R11 sent", 32'(sent[4]), 1);
    chk("R11 not canc", 32'(canc[4]), 0);
    chk("R11 idle", 32'(sel_valid), 0);
    do_arm(8'b0001_0000);
    do_start();
    do_cancel(8'b0001_0000);
    do_lost();
    chk("R12 canc", 32'(canc[4]), 1);
    chk("R12 not sent", 32'(sent[4]), 0);
    chk("R12 removed", 32'(sel_valid), 0);
  endtask

  task automatic t_rearm();
    do_arm(8'b0001_0000);
    chk("R13 canc cleared", 32'(canc[4]), 0);
    serve("R13 re-offered", 4);
    chk("R13 sent", 32'(sent[4]), 1);
    do_arm(8'b0001_0000);
    chk("R13 sent cleared", 32'(sent[4]), 0);
    do_start();
    do_arm(8'b0001_0000);
    do_done();
    chk("R13 arm in flight ignored", 32'(sent[4]), 1);
    chk("R13 not pending", 32'(sel_valid), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_low_id();
    t_std_ext();
    t_low_idx();
    t_local();
    t_tie();
    t_lost();
    t_cancel_idle();
    t_cancel_fly();
    t_rearm();
    summary();
  end
endmodule